// File: doc/BRIEF.md
# Embedded Sync Code Detector

This block sits on a camera pixel byte stream and recovers line and frame timing from marker codes carried inside the data. It is used in place of separate horizontal and vertical sync wires. When embedded mode is on, it looks for a reserved three-byte preamble (all ones, then all zeros, then all zeros). It treats the byte that follows as a code and compares it against four programmable codes. Each code has its own unmask, so only selected bits take part in the comparison. A recognised code raises a one-cycle event pulse and updates the line-valid and frame-valid levels. An event that arrives out of order sets a sticky error flag.

When embedded mode is off, the same outputs are derived from the discrete sync inputs instead. In either mode, bytes that arrive while a line is open are passed on as pixels. Preamble and code bytes are never passed on.

Top module: `esync_detect`

## Requirements
- R1: The 32-bit code word holds four 8-bit codes: bits 7:0 frame start, bits 15:8 line start, bits 23:16 line end, bits 31:24 frame end. The unmask word uses the same field layout. A code matches when every bit whose unmask bit is 1 equals the same bit of the code byte.
- R2: In embedded mode, a byte is examined as a code only when it directly follows the valid bytes FF, 00, 00. Bytes anywhere else never cause an event, even if their value equals a programmed code.
- R3: When several codes match, only one event is raised, in this priority: frame start, frame end, line start, line end. A code byte that matches no code raises no event.
- R4: Each event pulse is high for exactly one cycle. It is visible after the clock edge that accepts the code byte.
- R5: Line-valid rises with a line start and falls with a line end or a frame end. Frame-valid rises with a frame start and falls with a frame end. Both change at the same edge as the pulse.
- R6: The error flag is set by any of these: a line start while a line is open, a line end while no line is open, or a frame end while no frame is open. Once set, it stays set.
- R7: A high clear input clears the error flag at the next edge. If an error occurs in the same cycle as the clear, the flag is set.
- R8: With embedded mode off, line-valid and frame-valid follow the horizontal and vertical sync inputs one edge later. Rising edges of those inputs give line-start and frame-start pulses, and falling edges give line-end and frame-end pulses. Preamble and code bytes have no effect.
- R9: A valid byte presented while line-valid is high is emitted in order on the pixel output, three valid input bytes later. The three preamble bytes and the code byte of a recognised marker are never emitted.
- R10: After reset, all pulses, both levels, the error flag and the pixel valid output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| esm_en | input | 1 | 1 = embedded sync codes, 0 = discrete sync inputs |
| din | input | DATA_W | Incoming stream byte |
| din_vld | input | 1 | Qualifies din |
| ext_hsync | input | 1 | Discrete line sync, high during active line |
| ext_vsync | input | 1 | Discrete frame sync, high during active frame |
| sync_codes | input | 4*DATA_W | Four programmed codes (layout in R1) |
| code_unmask | input | 4*DATA_W | Per-code compare enables (layout in R1) |
| err_clr | input | 1 | Clears the sticky error flag |
| frame_start | output | 1 | Frame start pulse |
| line_start | output | 1 | Line start pulse |
| line_end | output | 1 | Line end pulse |
| frame_end | output | 1 | Frame end pulse |
| line_valid | output | 1 | Line open level |
| frame_valid | output | 1 | Frame open level |
| err_flag | output | 1 | Sticky protocol error |
| pix_data | output | DATA_W | Passed-through pixel byte |
| pix_valid | output | 1 | Qualifies pix_data |

## Verification
The bench builds the block with the default DATA_W of 8, so the preamble is FF 00 00 and the codes are the four byte fields of a 32-bit word. At that width, a partial unmask of four bits accepts a range of sixteen code values. Clearing whole unmask fields makes every byte match, which brings each priority pairing within reach. Because pixel bytes use that same width, an FF data byte just ahead of a preamble, or a broken FF 00 pattern inside a line, can be driven to show that only real markers are removed from the pixel stream.

// File: rtl/esync_pkg.sv
// Shared types for the embedded sync code detector.
// Assumes four codes per code word, in the field order frame start,
// line start, line end, frame end (low field to high field).
package esync_pkg;
    localparam int CODE_CNT = 4;
    localparam int IDX_FS   = 0;
    localparam int IDX_LS   = 1;
    localparam int IDX_LE   = 2;
    localparam int IDX_FE   = 3;
    localparam int PRE_LEN  = 3;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_FS,
        EV_FE,
        EV_LS,
        EV_LE
    } esync_ev_e;

    typedef enum logic [1:0] {
        PA_IDLE,
        PA_ONES,
        PA_ZERO1,
        PA_ZERO2
    } pre_st_e;
endpackage

// File: rtl/esync_preamble.sv
// Preamble tracker: follows the valid byte stream and flags the byte that
// directly follows an all-ones, all-zeros, all-zeros run.
// Assumes en is the embedded mode select; the tracker is held idle when off.
module esync_preamble
    import esync_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    input  logic              din_vld,
    output logic              code_now
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] ALL_ZERO = '0;

    pre_st_e st;

    // Advance the preamble state on every valid byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st <= PA_IDLE;
        end else if (din_vld) begin
            case (st)
                PA_IDLE:  st <= (din == ALL_ONES) ? PA_ONES : PA_IDLE;
                PA_ONES:  st <= (din == ALL_ZERO) ? PA_ZERO1 :
                                (din == ALL_ONES) ? PA_ONES : PA_IDLE;
                PA_ZERO1: st <= (din == ALL_ZERO) ? PA_ZERO2 :
                                (din == ALL_ONES) ? PA_ONES : PA_IDLE;
                default:  st <= PA_IDLE;
            endcase
        end
    end

    // The current byte is a code byte when the full preamble was seen.
    always_comb code_now = en && din_vld && (st == PA_ZERO2);
endmodule

// File: rtl/esync_match.sv
// Code matcher: compares one byte with four programmed codes under their
// unmask fields and returns the single highest-priority event.
// Assumes a 1 in the unmask marks a bit that takes part in the compare.
module esync_match
    import esync_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]          code_byte,
    input  logic [CODE_CNT*DATA_W-1:0] codes,
    input  logic [CODE_CNT*DATA_W-1:0] unmask,
    output esync_ev_e                  ev
);
    logic [CODE_CNT-1:0] hit;

    for (genvar i = 0; i < CODE_CNT; i++) begin : g_cmp
        // Masked compare of the byte against code field i.
        always_comb hit[i] = (((code_byte ^ codes[i*DATA_W +: DATA_W])
                               & unmask[i*DATA_W +: DATA_W]) == '0);
    end

    // Priority: frame start, frame end, line start, line end.
    always_comb begin
        if (hit[IDX_FS])      ev = EV_FS;
        else if (hit[IDX_FE]) ev = EV_FE;
        else if (hit[IDX_LS]) ev = EV_LS;
        else if (hit[IDX_LE]) ev = EV_LE;
        else                  ev = EV_NONE;
    end
endmodule

// File: rtl/esync_frame.sv
// Framing tracker: turns decoded events (embedded mode) or sync wire levels
// (discrete mode) into event pulses, line/frame levels and a sticky error.
// Assumes ev is only meaningful while ev_vld is high.
module esync_frame
    import esync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      esm_en,
    input  logic      ev_vld,
    input  esync_ev_e ev,
    input  logic      ext_hsync,
    input  logic      ext_vsync,
    input  logic      err_clr,
    output logic      fs_p,
    output logic      ls_p,
    output logic      le_p,
    output logic      fe_p,
    output logic      line_open,
    output logic      frame_open,
    output logic      err_flag
);
    logic lo_n, fo_n, fs_n, ls_n, le_n, fe_n, err_hit;

    // Next-state decode for both sync sources.
    always_comb begin
        lo_n = line_open;
        fo_n = frame_open;
        fs_n = 1'b0;
        ls_n = 1'b0;
        le_n = 1'b0;
        fe_n = 1'b0;
        err_hit = 1'b0;
        if (!esm_en) begin
            lo_n = ext_hsync;
            fo_n = ext_vsync;
            fs_n = ext_vsync && !frame_open;
            fe_n = !ext_vsync && frame_open;
            ls_n = ext_hsync && !line_open;
            le_n = !ext_hsync && line_open;
        end else if (ev_vld) begin
            case (ev)
                EV_FS: begin
                    fs_n = 1'b1;
                    fo_n = 1'b1;
                end
                EV_FE: begin
                    fe_n = 1'b1;
                    err_hit = !frame_open;
                    fo_n = 1'b0;
                    lo_n = 1'b0;
                end
                EV_LS: begin
                    ls_n = 1'b1;
                    err_hit = line_open;
                    lo_n = 1'b1;
                end
                EV_LE: begin
                    le_n = 1'b1;
                    err_hit = !line_open;
                    lo_n = 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Register the pulses, the levels and the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_p <= 1'b0;
            ls_p <= 1'b0;
            le_p <= 1'b0;
            fe_p <= 1'b0;
            line_open <= 1'b0;
            frame_open <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            fs_p <= fs_n;
            ls_p <= ls_n;
            le_p <= le_n;
            fe_p <= fe_n;
            line_open <= lo_n;
            frame_open <= fo_n;
            err_flag <= (err_flag && !err_clr) || err_hit;
        end
    end

    assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(esm_en) |-> $onehot0({fs_p, ls_p, le_p, fe_p}));
    assert_ls_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ls_p |=> !ls_p);
    assert_line_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_open) |-> ls_p);
    assert_frame_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_open) |-> fe_p);
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
endmodule

// File: rtl/esync_pixq.sv
// Pixel delay line: holds the last DEPTH valid bytes with a pixel tag so
// that a recognised marker can drop its preamble before it is emitted.
// Assumes squash arrives with the code byte, when the line holds the preamble.
module esync_pixq #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              din_vld,
    input  logic              tag_in,
    input  logic              squash,
    output logic [DATA_W-1:0] pix_data,
    output logic              pix_vld
);
    logic [DATA_W-1:0] data_q [DEPTH];
    logic              tag_q  [DEPTH];

    // Shift on each valid byte, or clear all tags on a marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_vld  <= 1'b0;
            pix_data <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                data_q[i] <= '0;
                tag_q[i]  <= 1'b0;
            end
        end else begin
            pix_vld <= 1'b0;
            if (din_vld) begin
                if (squash) begin
                    for (int i = 0; i < DEPTH; i++) tag_q[i] <= 1'b0;
                end else begin
                    pix_vld  <= tag_q[DEPTH-1];
                    pix_data <= data_q[DEPTH-1];
                    for (int i = DEPTH-1; i > 0; i--) begin
                        data_q[i] <= data_q[i-1];
                        tag_q[i]  <= tag_q[i-1];
                    end
                    data_q[0] <= din;
                    tag_q[0]  <= tag_in;
                end
            end
        end
    end

    assert_pix_needs_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> $past(din_vld));
endmodule

// File: rtl/esync_detect.sv
// Embedded sync code detector top: preamble tracker, code matcher,
// framing tracker and pixel delay line.
// Assumes the stream is byte-qualified by din_vld and the codes are stable
// while embedded mode is on.
module esync_detect
    import esync_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       esm_en,
    input  logic [DATA_W-1:0]          din,
    input  logic                       din_vld,
    input  logic                       ext_hsync,
    input  logic                       ext_vsync,
    input  logic [CODE_CNT*DATA_W-1:0] sync_codes,
    input  logic [CODE_CNT*DATA_W-1:0] code_unmask,
    input  logic                       err_clr,
    output logic                       frame_start,
    output logic                       line_start,
    output logic                       line_end,
    output logic                       frame_end,
    output logic                       line_valid,
    output logic                       frame_valid,
    output logic                       err_flag,
    output logic [DATA_W-1:0]          pix_data,
    output logic                       pix_valid
);
    logic      code_now;
    esync_ev_e ev;

    esync_preamble #(.DATA_W(DATA_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(esm_en),
        .din(din), .din_vld(din_vld), .code_now(code_now)
    );

    esync_match #(.DATA_W(DATA_W)) u_match (
        .code_byte(din), .codes(sync_codes), .unmask(code_unmask), .ev(ev)
    );

    esync_frame u_frame (
        .clk(clk), .rst_n(rst_n), .esm_en(esm_en),
        .ev_vld(code_now), .ev(ev),
        .ext_hsync(ext_hsync), .ext_vsync(ext_vsync), .err_clr(err_clr),
        .fs_p(frame_start), .ls_p(line_start), .le_p(line_end), .fe_p(frame_end),
        .line_open(line_valid), .frame_open(frame_valid), .err_flag(err_flag)
    );

    esync_pixq #(.DATA_W(DATA_W), .DEPTH(PRE_LEN)) u_pixq (
        .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
        .tag_in(line_valid), .squash(code_now),
        .pix_data(pix_data), .pix_vld(pix_valid)
    );
endmodule

// File: tb/esync_detect_tb.sv
module esync_detect_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        esm_en = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        din_vld = 1'b0;
    logic        ext_hsync = 1'b0;
    logic        ext_vsync = 1'b0;
    logic [31:0] sync_codes = 32'hC7B6A080;
    logic [31:0] code_unmask = 32'hFFFFF0FF;
    logic        err_clr = 1'b0;
    logic frame_start, line_start, line_end, frame_end;
    logic line_valid, frame_valid, err_flag, pix_valid;
    logic [7:0] pix_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit m_lo = 1'b0, m_fo = 1'b0, m_err = 1'b0;
    logic [7:0] pix_q[$];
    logic [3:0] ev_q[$];

    localparam logic [3:0] FS = 4'b1000, LS = 4'b0100, LE = 4'b0010, FE = 4'b0001, NO = 4'b0000;

    always #10 clk = ~clk;

    esync_detect u_dut (
        .clk(clk), .rst_n(rst_n), .esm_en(esm_en), .din(din), .din_vld(din_vld),
        .ext_hsync(ext_hsync), .ext_vsync(ext_vsync), .sync_codes(sync_codes),
        .code_unmask(code_unmask), .err_clr(err_clr),
        .frame_start(frame_start), .line_start(line_start), .line_end(line_end),
        .frame_end(frame_end), .line_valid(line_valid), .frame_valid(frame_valid),
        .err_flag(err_flag), .pix_data(pix_data), .pix_valid(pix_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input bit clr = 1'b0);
        din = b;
        din_vld = 1'b1;
        err_clr = clr;
        @(negedge clk);
        din_vld = 1'b0;
        err_clr = 1'b0;
    endtask

    // Byte inside the stream; expected as pixel if the model line is open.
    task automatic pix(input logic [7:0] b);
        if (m_lo) pix_q.push_back(b);
        put(b);
    endtask

    // Full marker: preamble, code byte, then level and error checks.
    task automatic code(input logic [7:0] b, input logic [3:0] ev, input bit clr = 1'b0);
        bit e;
        put(8'hFF);
        put(8'h00);
        put(8'h00);
        e = 1'b0;
        case (ev)
            FS: m_fo = 1'b1;
            FE: begin e = !m_fo; m_fo = 1'b0; m_lo = 1'b0; end
            LS: begin e = m_lo; m_lo = 1'b1; end
            LE: begin e = !m_lo; m_lo = 1'b0; end
            default: ;
        endcase
        m_err = (m_err && !clr) || e;
        if (ev != NO) ev_q.push_back(ev);
        put(b, clr);
        if (ev == NO)
            check({frame_start, line_start, line_end, frame_end} == 4'b0, "R3 no event",
                  {frame_start, line_start, line_end, frame_end}, 0);
        check(line_valid == m_lo, "R5 line_valid", line_valid, m_lo);
        check(frame_valid == m_fo, "R5 frame_valid", frame_valid, m_fo);
        check(err_flag == m_err, "R6 err_flag", err_flag, m_err);
    endtask

    task automatic clr_only();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        m_err = 1'b0;
        check(err_flag == 1'b0, "R7 err cleared", err_flag, 0);
    endtask

    // Scoreboard monitor: pixels and event pulses against the queues.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] pv;
            pv = {frame_start, line_start, line_end, frame_end};
            if (pix_valid) begin
                if (pix_q.size() == 0) check(1'b0, "R9 unexpected pixel", pix_data, 0);
                else begin
                    logic [7:0] ep;
                    ep = pix_q.pop_front();
                    check(pix_data == ep, "R9 pixel", pix_data, ep);
                end
            end
            if (pv != 4'b0) begin
                if (ev_q.size() == 0) check(1'b0, "R2 unexpected event", pv, 0);
                else begin
                    logic [3:0] ee;
                    ee = ev_q.pop_front();
                    check(pv == ee, "R4 event pulse", pv, ee);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check({frame_start, line_start, line_end, frame_end, line_valid, frame_valid,
               err_flag, pix_valid} == 8'b0, "R10 reset outputs",
              {frame_start, line_start, line_end, frame_end, line_valid, frame_valid,
               err_flag, pix_valid}, 0);
        rst_n = 1'b1;
        esm_en = 1'b1;
        @(negedge clk);

        // Basic frame and line with pixels; FF data byte ahead of a preamble (R9)
        code(8'h80, FS);
        code(8'hA0, LS);
        pix(8'h11); pix(8'h12); pix(8'h13); pix(8'hFF);
        code(8'hB6, LE);

        // R2: code values outside a marker, and a broken preamble
        put(8'h80); put(8'hFF); put(8'h00); put(8'h55); put(8'hB6);
        check(line_valid == 1'b0, "R2 no line opened", line_valid, 0);

        // R3: marker with a byte matching nothing
        code(8'h55, NO);

        // R1: partial unmask on the line start field, plus broken pattern pixels
        code(8'hA7, LS);
        pix(8'hFF); pix(8'h00); pix(8'h11);
        code(8'hB6, LE);

        // R6: line end with no line open, then sticky
        code(8'hB6, LE);
        put(8'h01);
        check(err_flag == 1'b1, "R6 err sticky", err_flag, 1);
        clr_only();

        // R7: error in the same cycle as clear
        code(8'hA0, LS);
        code(8'hA1, LS, 1'b1);
        code(8'hB6, LE);
        clr_only();

        // R6: frame end with no frame open
        code(8'hC7, FE);
        code(8'hC7, FE);
        clr_only();

        // R3 priority: frame end field fully masked
        code_unmask = 32'h00FFF0FF;
        code(8'h80, FS);
        code(8'hA3, FE);
        // R3 priority: line start and line end fields fully masked
        code_unmask = 32'hFF0000FF;
        code(8'hB6, LS);
        code_unmask = 32'hFFFFF0FF;
        code(8'hB6, LE);
        check(err_flag == 1'b0, "R3 no error in priority run", err_flag, 0);

        // R8: discrete mode
        esm_en = 1'b0;
        @(negedge clk);
        ev_q.push_back(FS);
        ext_vsync = 1'b1;
        @(negedge clk);
        check(frame_valid == 1'b1, "R8 frame_valid follows vsync", frame_valid, 1);
        ev_q.push_back(LS);
        ext_hsync = 1'b1;
        @(negedge clk);
        check(line_valid == 1'b1, "R8 line_valid follows hsync", line_valid, 1);
        m_lo = 1'b1;
        pix(8'h21); pix(8'h22);
        pix(8'hFF); pix(8'h00); pix(8'h00); pix(8'hA0);
        check(line_valid == 1'b1, "R8 codes ignored", line_valid, 1);
        ev_q.push_back(LE);
        ext_hsync = 1'b0;
        @(negedge clk);
        m_lo = 1'b0;
        check(line_valid == 1'b0, "R8 line_valid falls", line_valid, 0);
        put(8'h01); put(8'h02); put(8'h03);
        ev_q.push_back(FE);
        ext_vsync = 1'b0;
        @(negedge clk);
        check(frame_valid == 1'b0, "R8 frame_valid falls", frame_valid, 0);
        repeat (2) @(negedge clk);

        check(pix_q.size() == 0, "R9 all pixels seen", pix_q.size(), 0);
        check(ev_q.size() == 0, "R4 all events seen", ev_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule